// File: doc/BRIEF.md
# One-Bit Phase Error Loop Filter

This block is the loop filter of a carrier-tracking phase lock loop that works on a single-bit phase error. On each valid sample it reads one error bit, taken either from an on-chip lookup path or from an external pin. A bit of 0 means +1 and a bit of 1 means -1. The signed unit is scaled by two independent power-of-two gains. The proportional gain acts on the current sample. The integral gain feeds a 32-bit accumulator. The 32-bit phase increment sent to a downstream NCO is the sum of a host-loaded frequency word, the accumulator and the proportional term.

The host writes the two shift constants into a pending bank. They reach the datapath only when an external sync strobe arrives, so the loop bandwidth can change at a known sample. Each gain also has a clear flag that sets it to zero. The host can preset the frequency word to an estimated offset, which speeds up acquisition. Clearing both gains and the accumulator leaves the frequency word as a fixed tuning value, which turns the block into a plain mixer tuning source. A hold input freezes the integrator and removes the proportional contribution. Shift values between about 24 and 31 suit the integral path, with the proportional shift near half of it for critical damping.

Top module: `lbf_loop_filter`

## Requirements
- R1: The error bit used is `err_ext` when `err_sel` is 1 and `err_lut` when `err_sel` is 0.
- R2: An error bit of 0 counts as +1 and an error bit of 1 counts as -1 in both gain paths.
- R3: On a valid sample the proportional term becomes ±2^(32-s), where s is the active proportional shift, in 32-bit two's complement. It is zero when s is 0, when s is 32 or more, or when the proportional clear flag is active. The term is held until the next valid sample.
- R4: On a valid sample the accumulator adds ±2^(32-s), where s is the active integral shift, modulo 2^32. The same zero rules apply, using the integral clear flag.
- R5: A `cfg_wr` pulse only loads the pending gains. The active gains take the pending values on the edge where `gain_sync` is 1, and they stay unchanged at every other edge.
- R6: `phase_inc` equals the frequency word plus the accumulator plus the proportional term, modulo 2^32.
- R7: A `freq_wr` pulse loads `freq_data` into the frequency word. The new value appears on `phase_inc` from the next cycle on.
- R8: While `phase_hold` is 1 the accumulator does not change, and the proportional term adds nothing to `phase_inc`.
- R9: An `acc_clr` pulse zeroes the accumulator and the proportional term on the next edge. It takes priority over a sample in the same cycle.
- R10: After reset the accumulator, the frequency word and `phase_inc` are zero, and both active gains are cleared.
- R11: `acc_value` shows the current accumulator contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_lut | input | 1 | Error bit from the lookup path |
| err_ext | input | 1 | Error bit from the external pin |
| err_sel | input | 1 | 1 selects the external error |
| err_valid | input | 1 | Error sample strobe |
| cfg_wr | input | 1 | Load the pending gain bank |
| cfg_prop_clr | input | 1 | Pending proportional clear flag |
| cfg_prop_shift | input | 6 | Pending proportional shift |
| cfg_int_clr | input | 1 | Pending integral clear flag |
| cfg_int_shift | input | 6 | Pending integral shift |
| gain_sync | input | 1 | Moves the pending gains to the active bank |
| freq_wr | input | 1 | Load the frequency word |
| freq_data | input | 32 | Frequency preset value |
| acc_clr | input | 1 | Zero the accumulator and proportional term |
| phase_hold | input | 1 | Freeze the loop |
| phase_inc | output | 32 | Phase increment to the NCO |
| acc_value | output | 32 | Accumulator read-back |

## Verification
A vector table runs an alternating series of +1 and -1 samples from both error sources with fixed gains. Cases where the pin and the lookup bit disagree show whether the mux picks the right source. A run of like signs against an alternating run separates the integral path from the proportional path, and a held sample shows that the proportional term is masked. Directed sequences then cover the gain values at the edges: shift 0, 31, 32 and above 32, the clear flags, and a shift of 1 that makes the accumulator wrap. They also cover writes that are not yet followed by a sync, an accumulator clear that arrives together with a sample, and mixer mode with a preset tuning word.

// File: rtl/lbf_pkg.sv
package lbf_pkg;

    localparam int PHASE_W = 32;
    localparam int SHIFT_W = 6;
    localparam int NUM_PATHS = 2;

    typedef enum int {
        PATH_PROP = 0,
        PATH_INT  = 1
    } path_e;

    typedef struct packed {
        logic               clr;
        logic [SHIFT_W-1:0] shift;
    } gain_cfg_t;

    localparam gain_cfg_t GAIN_OFF = '{clr: 1'b1, shift: '0};

    // Map a one-bit error to its sign: 0 is positive, 1 is negative.
    function automatic logic err_is_negative(input logic err_bit);
        return err_bit;
    endfunction

endpackage

// File: rtl/lbf_gain_bank.sv
module lbf_gain_bank
    import lbf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  gain_cfg_t wr_cfg,
    input  logic      sync,
    output gain_cfg_t active
);

    gain_cfg_t pending_q;
    gain_cfg_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= GAIN_OFF;
            active_q  <= GAIN_OFF;
        end else begin
            if (wr)
                pending_q <= wr_cfg;
            if (sync)
                active_q <= pending_q;
        end
    end

    assign active = active_q;

    // R5
    gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sync |=> $stable(active_q));

    // R5
    gain_load_chk: assert property (@(posedge clk) disable iff (rst)
        sync |=> (active_q == $past(pending_q)));

endmodule

// File: rtl/lbf_err_scale.sv
module lbf_err_scale
    import lbf_pkg::*;
#(
    parameter int W = PHASE_W
) (
    input  gain_cfg_t    cfg,
    input  logic         neg,
    output logic [W-1:0] term
);

    localparam logic [W-1:0] ONE = W'(1);

    logic         in_range;
    logic [W-1:0] mag;

    always_comb begin
        in_range = (cfg.shift != '0) && (int'(cfg.shift) < W);
        mag      = '0;
        if (!cfg.clr && in_range)
            mag = ONE << (W - int'(cfg.shift));
        term = neg ? (~mag + ONE) : mag;
    end

endmodule

// File: rtl/lbf_integrator.sv
module lbf_integrator #(
    parameter int W = lbf_pkg::PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         hold,
    input  logic         valid,
    input  logic [W-1:0] step,
    output logic [W-1:0] acc
);

    logic [W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (valid && !hold)
            acc_q <= acc_q + step;
    end

    assign acc = acc_q;

    // R8
    acc_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !clr) |=> $stable(acc_q));

    // R9
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0));

    // R4
    acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid && !clr) |=> $stable(acc_q));

endmodule

// File: rtl/lbf_loop_filter.sv
module lbf_loop_filter
    import lbf_pkg::*;
#(
    parameter int W   = PHASE_W,
    parameter int SHW = SHIFT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           err_lut,
    input  logic           err_ext,
    input  logic           err_sel,
    input  logic           err_valid,
    input  logic           cfg_wr,
    input  logic           cfg_prop_clr,
    input  logic [SHW-1:0] cfg_prop_shift,
    input  logic           cfg_int_clr,
    input  logic [SHW-1:0] cfg_int_shift,
    input  logic           gain_sync,
    input  logic           freq_wr,
    input  logic [W-1:0]   freq_data,
    input  logic           acc_clr,
    input  logic           phase_hold,
    output logic [W-1:0]   phase_inc,
    output logic [W-1:0]   acc_value
);

    gain_cfg_t    wr_cfg [NUM_PATHS];
    gain_cfg_t    act_cfg[NUM_PATHS];
    logic [W-1:0] term   [NUM_PATHS];

    logic         err_bit;
    logic         err_neg;
    logic [W-1:0] freq_q;
    logic [W-1:0] prop_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] prop_eff;

    assign wr_cfg[PATH_PROP] = '{clr: cfg_prop_clr, shift: cfg_prop_shift};
    assign wr_cfg[PATH_INT]  = '{clr: cfg_int_clr,  shift: cfg_int_shift};

    assign err_bit = err_sel ? err_ext : err_lut;
    assign err_neg = err_is_negative(err_bit);

    generate
        for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
            lbf_gain_bank u_bank (
                .clk    (clk),
                .rst    (rst),
                .wr     (cfg_wr),
                .wr_cfg (wr_cfg[p]),
                .sync   (gain_sync),
                .active (act_cfg[p])
            );

            lbf_err_scale #(.W(W)) u_scale (
                .cfg  (act_cfg[p]),
                .neg  (err_neg),
                .term (term[p])
            );
        end
    endgenerate

    lbf_integrator #(.W(W)) u_integ (
        .clk   (clk),
        .rst   (rst),
        .clr   (acc_clr),
        .hold  (phase_hold),
        .valid (err_valid),
        .step  (term[PATH_INT]),
        .acc   (acc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q <= '0;
            prop_q <= '0;
        end else begin
            if (freq_wr)
                freq_q <= freq_data;
            if (acc_clr)
                prop_q <= '0;
            else if (err_valid)
                prop_q <= phase_hold ? '0 : term[PATH_PROP];
        end
    end

    assign prop_eff  = phase_hold ? '0 : prop_q;
    assign phase_inc = freq_q + acc_q + prop_eff;
    assign acc_value = acc_q;

    // R8
    hold_no_prop_chk: assert property (@(posedge clk) disable iff (rst)
        phase_hold |-> (phase_inc == freq_q + acc_q));

    // R3
    prop_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!err_valid && !acc_clr) |=> $stable(prop_q));

    // R7
    freq_load_chk: assert property (@(posedge clk) disable iff (rst)
        freq_wr |=> (freq_q == $past(freq_data)));

endmodule

// File: tb/tb_lbf_loop_filter.sv
module tb_lbf_loop_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_lut = 0, err_ext = 0, err_sel = 0, err_valid = 0;
    logic        cfg_wr = 0, cfg_prop_clr = 0, cfg_int_clr = 0;
    logic [5:0]  cfg_prop_shift = '0, cfg_int_shift = '0;
    logic        gain_sync = 0, freq_wr = 0, acc_clr = 0, phase_hold = 0;
    logic [31:0] freq_data = '0;
    logic [31:0] phase_inc, acc_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lbf_loop_filter dut (
        .clk(clk), .rst(rst),
        .err_lut(err_lut), .err_ext(err_ext), .err_sel(err_sel), .err_valid(err_valid),
        .cfg_wr(cfg_wr), .cfg_prop_clr(cfg_prop_clr), .cfg_prop_shift(cfg_prop_shift),
        .cfg_int_clr(cfg_int_clr), .cfg_int_shift(cfg_int_shift),
        .gain_sync(gain_sync), .freq_wr(freq_wr), .freq_data(freq_data),
        .acc_clr(acc_clr), .phase_hold(phase_hold),
        .phase_inc(phase_inc), .acc_value(acc_value)
    );

    typedef struct packed {
        logic        sel;
        logic        lut;
        logic        ext;
        logic        hold;
        logic [31:0] acc;
        logic [31:0] ph;
    } vec_t;

    // Gains: proportional shift 4 (step 0x1000_0000), integral shift 8
    // (step 0x0100_0000), frequency word 0x1000_0000.
    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0100_0000, 32'h2100_0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'h0100_0000, 32'h2100_0000},
        '{1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000},
        '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0100_0000, 32'h2100_0000},
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0200_0000, 32'h2200_0000},
        '{1'b0, 1'b1, 1'b0, 1'b1, 32'h0200_0000, 32'h1200_0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 32'h0100_0000, 32'h0100_0000}
    };

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_gains(input logic pc, input logic [5:0] ps,
                             input logic ic, input logic [5:0] is, input bit do_sync);
        @(negedge clk);
        cfg_wr = 1; cfg_prop_clr = pc; cfg_prop_shift = ps;
        cfg_int_clr = ic; cfg_int_shift = is;
        @(negedge clk);
        cfg_wr = 0;
        if (do_sync) begin
            gain_sync = 1;
            @(negedge clk);
            gain_sync = 0;
        end
    endtask

    task automatic load_freq(input logic [31:0] f);
        @(negedge clk);
        freq_wr = 1; freq_data = f;
        @(negedge clk);
        freq_wr = 0;
    endtask

    task automatic clear_acc();
        @(negedge clk);
        acc_clr = 1;
        @(negedge clk);
        acc_clr = 0;
    endtask

    // Drive one valid sample at a negedge; returns at the following negedge.
    task automatic sample(input logic sel, input logic lut, input logic ext, input logic hold);
        @(negedge clk);
        err_sel = sel; err_lut = lut; err_ext = ext; phase_hold = hold; err_valid = 1;
        @(negedge clk);
        err_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: reset state
        check32("R10 phase_inc", phase_inc, 32'h0);
        check32("R10 acc_value", acc_value, 32'h0);

        // R10: active gains cleared, so a sample moves nothing
        sample(1'b0, 1'b0, 1'b0, 1'b0);
        check32("R10 gains off", phase_inc, 32'h0);

        // R7: frequency preset
        load_freq(32'h1000_0000);
        check32("R7 preset", phase_inc, 32'h1000_0000);

        // R5: written but not synced -> no effect
        set_gains(1'b0, 6'd4, 1'b0, 6'd8, 1'b0);
        sample(1'b0, 1'b0, 1'b0, 1'b0);
        check32("R5 pending acc", acc_value, 32'h0);
        check32("R5 pending phase", phase_inc, 32'h1000_0000);
        @(negedge clk);
        gain_sync = 1;
        @(negedge clk);
        gain_sync = 0;

        // R1/R2/R3/R4/R6/R8/R11 vector walk
        foreach (VEC[i]) begin
            sample(VEC[i].sel, VEC[i].lut, VEC[i].ext, VEC[i].hold);
            check32($sformatf("R4/R11 vec %0d acc", i), acc_value, VEC[i].acc);
            check32($sformatf("R1/R2/R3/R6/R8 vec %0d phase", i), phase_inc, VEC[i].ph);
        end
        phase_hold = 0;

        // R9: clear wins over a same-cycle sample
        @(negedge clk);
        acc_clr = 1; err_sel = 0; err_lut = 0; err_valid = 1;
        @(negedge clk);
        acc_clr = 0; err_valid = 0;
        check32("R9 acc", acc_value, 32'h0);
        check32("R9 phase", phase_inc, 32'h1000_0000);

        // R3: proportional clear flag
        set_gains(1'b1, 6'd4, 1'b0, 6'd8, 1'b1);
        sample(1'b0, 1'b0, 1'b0, 1'b0);
        check32("R3 clr acc", acc_value, 32'h0100_0000);
        check32("R3 clr phase", phase_inc, 32'h1100_0000);

        // R3/R4: shift 32, 40 and 0 give zero
        clear_acc();
        set_gains(1'b0, 6'd32, 1'b0, 6'd40, 1'b1);
        sample(1'b0, 1'b1, 1'b0, 1'b0);
        check32("R4 shift40 acc", acc_value, 32'h0);
        check32("R3 shift32 phase", phase_inc, 32'h1000_0000);
        set_gains(1'b0, 6'd0, 1'b0, 6'd32, 1'b1);
        sample(1'b0, 1'b0, 1'b0, 1'b0);
        check32("R4 shift32 acc", acc_value, 32'h0);
        check32("R3 shift0 phase", phase_inc, 32'h1000_0000);

        // R3/R4: shift 31 gives a step of 2
        set_gains(1'b0, 6'd31, 1'b0, 6'd31, 1'b1);
        sample(1'b0, 1'b0, 1'b0, 1'b0);
        check32("R4 shift31 acc", acc_value, 32'h2);
        check32("R3 shift31 phase", phase_inc, 32'h1000_0004);

        // R4: accumulator wraps modulo 2^32
        clear_acc();
        set_gains(1'b1, 6'd0, 1'b0, 6'd1, 1'b1);
        sample(1'b0, 1'b0, 1'b0, 1'b0);
        check32("R4 half", acc_value, 32'h8000_0000);
        sample(1'b0, 1'b0, 1'b0, 1'b0);
        check32("R4 wrap", acc_value, 32'h0);

        // R6: sum wraps modulo 2^32
        set_gains(1'b0, 6'd1, 1'b1, 6'd0, 1'b1);
        load_freq(32'hFFFF_FFF0);
        sample(1'b1, 1'b1, 1'b0, 1'b0);
        check32("R6 wrap", phase_inc, 32'h7FFF_FFF0);

        // R9/R7: mixer mode, fixed tuning word
        set_gains(1'b1, 6'd4, 1'b1, 6'd8, 1'b1);
        clear_acc();
        load_freq(32'h1234_5678);
        sample(1'b0, 1'b1, 1'b1, 1'b0);
        sample(1'b1, 1'b1, 1'b1, 1'b0);
        check32("R9 mixer phase", phase_inc, 32'h1234_5678);
        check32("R9 mixer acc", acc_value, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule